// File: doc/BRIEF.md
# Cache-Operation Access Protection Checker

This block sits in the pipeline stage after address translation. It decides how a cache-management operation is handled. Each cycle it can take one request. A request carries an operation code, the privilege mode, whether relocation is enabled, whether translation hit, the write-enable bit of the matching page, and the 2-bit zone code selected for that page's zone. One cycle later it returns a registered verdict: proceed, suppress as a no-op, data-storage interrupt, TLB-miss interrupt, or program (privilege) interrupt.

Each cache operation has its own protection rule. Operations that only move existing data back to memory, or only read the cache, are checked like loads, so the page write-enable bit does not affect them. Speculative hints never trap: if they would be denied, they quietly become no-ops. Privileged operations skip the zone check altogether. The translation buffer, the zone registers and the cache arrays are outside this block.

Top module: `cache_op_guard`

## Requirements
- R1: The verdict is registered. `rsp_valid_o` is high exactly one cycle after a cycle with `req_valid_i` high, and a new request is accepted every cycle. The response codes are: 0 proceed, 1 no-op, 2 data-storage interrupt, 3 TLB-miss interrupt, 4 program interrupt. While `rsp_valid_o` is low, `rsp_code_o` is 0.
- R2: While `rst_ni` is low, `rsp_valid_o` and `rsp_code_o` are 0.
- R3: In user mode (`user_mode_i`=1), a privileged operation gives code 4, ahead of every other check. The privileged operations are op codes 7, 8, 9, 10, 11 and 12.
- R4: For a recognised operation (op codes 1 to 12) that R3 has not caught, `reloc_en_i`=0 gives code 0 whatever the translation and protection inputs are.
- R5: For a recognised operation with relocation enabled and `xlat_hit_i`=0, the result is code 3. A translation miss takes priority over every protection outcome.
- R6: Block allocate-zero (op 1) gives code 1 when `page_wr_en_i`=0. It also gives code 1 when in user mode with zone code 00. Otherwise it gives code 0. It never traps.
- R7: Block flush (op 2) and block store-back (op 3) ignore `page_wr_en_i`. They give code 2 in user mode with zone code 00, and code 0 otherwise.
- R8: Data touch (op 4), data touch-for-store (op 5) and instruction touch (op 6) ignore `page_wr_en_i`. They give code 1 in user mode with zone code 00, and code 0 otherwise.
- R9: Data block invalidate (op 7) gives code 2 when `page_wr_en_i`=0. The zone code never changes its result.
- R10: Data-cache read (op 8), instruction block invalidate (op 9) and instruction-cache read (op 10) give code 0 for every write-enable and zone value.
- R11: Data congruence-class invalidate (op 11) gives code 2 when `page_wr_en_i`=0. Instruction congruence-class invalidate (op 12) gives code 0 for every write-enable and zone value.
- R12: Op codes 0, 13, 14 and 15 are not cache operations. They always give code 0, in any mode, with a hit or a miss.
- R13: Zone code 00 denies access only in user mode. Zone codes 01, 10 and 11, and any zone code in supervisor mode, never change the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request strobe |
| req_op_i | input | 4 | Cache operation code |
| user_mode_i | input | 1 | 1 = user mode, 0 = supervisor mode |
| reloc_en_i | input | 1 | Data relocation enabled |
| page_wr_en_i | input | 1 | Write-enable bit of the matching page |
| zone_code_i | input | 2 | Zone protection code for the page's zone |
| xlat_hit_i | input | 1 | Translation hit |
| rsp_valid_o | output | 1 | Verdict valid |
| rsp_code_o | output | 3 | Verdict code |

## Verification
The assertions check the following on every cycle:
- the one-cycle valid timing and the zero code while idle;
- the clear state in reset;
- the user-mode privilege trap;
- the relocation-off bypass;
- the miss priority;
- that touch hints and allocate-zero never produce a trap code.

The per-operation protection table can only be shown by the bench's sweep of every operation against every mode, relocation, write-enable, zone and hit combination:
- write-enable ignored for load-like operations;
- zone codes other than 00 ignored;
- unrecognised codes passing through.

Back-to-back acceptance and the gap behaviour also depend on those scenarios.

// File: rtl/cachk_pkg.sv
package cachk_pkg;
  localparam int unsigned OP_W   = 4;
  localparam int unsigned ZONE_W = 2;
  localparam int unsigned RES_W  = 3;

  typedef enum logic [RES_W-1:0] {
    RES_PROCEED = 3'd0,
    RES_NOP     = 3'd1,
    RES_DSI     = 3'd2,
    RES_TLB     = 3'd3,
    RES_PRIV    = 3'd4
  } res_e;

  // action taken when a given check fails
  typedef enum logic [1:0] {
    DENY_NONE = 2'd0,
    DENY_NOP  = 2'd1,
    DENY_DSI  = 2'd2
  } deny_e;

  typedef struct packed {
    logic  known;
    logic  priv;
    deny_e on_wr;
    deny_e on_zone;
  } op_attr_t;

  localparam logic [OP_W-1:0] OP_NONE     = 4'd0;
  localparam logic [OP_W-1:0] OP_ALLOC    = 4'd1;
  localparam logic [OP_W-1:0] OP_FLUSH    = 4'd2;
  localparam logic [OP_W-1:0] OP_STBACK   = 4'd3;
  localparam logic [OP_W-1:0] OP_DTOUCH   = 4'd4;
  localparam logic [OP_W-1:0] OP_DTOUCHST = 4'd5;
  localparam logic [OP_W-1:0] OP_ITOUCH   = 4'd6;
  localparam logic [OP_W-1:0] OP_DINV     = 4'd7;
  localparam logic [OP_W-1:0] OP_DREAD    = 4'd8;
  localparam logic [OP_W-1:0] OP_IINV     = 4'd9;
  localparam logic [OP_W-1:0] OP_IREAD    = 4'd10;
  localparam logic [OP_W-1:0] OP_DCCINV   = 4'd11;
  localparam logic [OP_W-1:0] OP_ICCINV   = 4'd12;
endpackage

// File: rtl/cachk_decode.sv
module cachk_decode
  import cachk_pkg::*;
(
  input  logic [OP_W-1:0] op_i,
  output op_attr_t        attr_o
);
  always_comb begin
    attr_o = '{known: 1'b0, priv: 1'b0, on_wr: DENY_NONE, on_zone: DENY_NONE};
    unique case (op_i)
      OP_ALLOC:    attr_o = '{known: 1'b1, priv: 1'b0, on_wr: DENY_NOP,  on_zone: DENY_NOP};
      OP_FLUSH,
      OP_STBACK:   attr_o = '{known: 1'b1, priv: 1'b0, on_wr: DENY_NONE, on_zone: DENY_DSI};
      OP_DTOUCH,
      OP_DTOUCHST,
      OP_ITOUCH:   attr_o = '{known: 1'b1, priv: 1'b0, on_wr: DENY_NONE, on_zone: DENY_NOP};
      OP_DINV,
      OP_DCCINV:   attr_o = '{known: 1'b1, priv: 1'b1, on_wr: DENY_DSI,  on_zone: DENY_NONE};
      OP_DREAD,
      OP_IINV,
      OP_IREAD,
      OP_ICCINV:   attr_o = '{known: 1'b1, priv: 1'b1, on_wr: DENY_NONE, on_zone: DENY_NONE};
      default:     attr_o = '{known: 1'b0, priv: 1'b0, on_wr: DENY_NONE, on_zone: DENY_NONE};
    endcase
  end
endmodule

// File: rtl/cachk_zone.sv
module cachk_zone
  import cachk_pkg::*;
#(
  parameter logic [ZONE_W-1:0] NO_ACCESS = '0
) (
  input  logic [ZONE_W-1:0] zone_i,
  input  logic              user_i,
  output logic              deny_o
);
  // supervisor mode is never denied by the zone check
  assign deny_o = user_i && (zone_i == NO_ACCESS);
endmodule

// File: rtl/cachk_classify.sv
module cachk_classify
  import cachk_pkg::*;
(
  input  op_attr_t attr_i,
  input  logic     user_i,
  input  logic     reloc_i,
  input  logic     hit_i,
  input  logic     wr_en_i,
  input  logic     zone_deny_i,
  output res_e     res_o
);
  deny_e wr_act, zn_act;

  always_comb begin
    wr_act = wr_en_i     ? DENY_NONE : attr_i.on_wr;
    zn_act = zone_deny_i ? attr_i.on_zone : DENY_NONE;
  end

  // priority: unknown > privilege > bypass > miss > DSI > no-op
  always_comb begin
    if (!attr_i.known)                           res_o = RES_PROCEED;
    else if (attr_i.priv && user_i)              res_o = RES_PRIV;
    else if (!reloc_i)                           res_o = RES_PROCEED;
    else if (!hit_i)                             res_o = RES_TLB;
    else if (wr_act == DENY_DSI || zn_act == DENY_DSI) res_o = RES_DSI;
    else if (wr_act == DENY_NOP || zn_act == DENY_NOP) res_o = RES_NOP;
    else                                         res_o = RES_PROCEED;
  end
endmodule

// File: rtl/cache_op_guard.sv
module cache_op_guard
  import cachk_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [OP_W-1:0]   req_op_i,
  input  logic              user_mode_i,
  input  logic              reloc_en_i,
  input  logic              page_wr_en_i,
  input  logic [ZONE_W-1:0] zone_code_i,
  input  logic              xlat_hit_i,
  output logic              rsp_valid_o,
  output logic [RES_W-1:0]  rsp_code_o
);
  op_attr_t attr;
  logic     zone_deny;
  res_e     res_d;

  cachk_decode u_decode (.op_i(req_op_i), .attr_o(attr));

  cachk_zone #(.NO_ACCESS('0)) u_zone (
    .zone_i (zone_code_i),
    .user_i (user_mode_i),
    .deny_o (zone_deny)
  );

  cachk_classify u_classify (
    .attr_i      (attr),
    .user_i      (user_mode_i),
    .reloc_i     (reloc_en_i),
    .hit_i       (xlat_hit_i),
    .wr_en_i     (page_wr_en_i),
    .zone_deny_i (zone_deny),
    .res_o       (res_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_code_o  <= '0;
    end else begin
      rsp_valid_o <= req_valid_i;
      rsp_code_o  <= req_valid_i ? res_d : RES_PROCEED;
    end
  end

  logic op_priv, op_known, op_touch;
  assign op_priv  = (req_op_i >= OP_DINV) && (req_op_i <= OP_ICCINV);
  assign op_known = (req_op_i >= OP_ALLOC) && (req_op_i <= OP_ICCINV);
  assign op_touch = (req_op_i == OP_DTOUCH) || (req_op_i == OP_DTOUCHST) ||
                    (req_op_i == OP_ITOUCH) || (req_op_i == OP_ALLOC);

  a_r1_valid_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);
  a_r1_valid_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o);
  a_r1_idle_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rsp_valid_o |-> rsp_code_o == '0);
  a_r2_reset_clear: assert property (@(posedge clk_i)
    !rst_ni |-> (!rsp_valid_o && rsp_code_o == '0));
  a_r3_user_priv: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && user_mode_i && op_priv) |=> rsp_code_o == RES_PRIV);
  a_r4_bypass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !reloc_en_i && !(user_mode_i && op_priv)) |=> rsp_code_o == RES_PROCEED);
  a_r5_miss_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && op_known && reloc_en_i && !xlat_hit_i && !(user_mode_i && op_priv))
      |=> rsp_code_o == RES_TLB);
  a_r8_hint_no_trap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && op_touch && xlat_hit_i) |=> rsp_code_o != RES_DSI);
endmodule

// File: tb/cache_op_guard_tb.sv
module cache_op_guard_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       req_valid_i = 1'b0;
  logic [3:0] req_op_i = '0;
  logic       user_mode_i = 1'b0;
  logic       reloc_en_i = 1'b0;
  logic       page_wr_en_i = 1'b0;
  logic [1:0] zone_code_i = '0;
  logic       xlat_hit_i = 1'b0;
  logic       rsp_valid_o;
  logic [2:0] rsp_code_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  cache_op_guard u_dut (.*);

  function automatic int expect_code(int op, bit usr, bit rel, bit wr, int zn, bit hit);
    bit zdeny = usr && (zn == 0);
    if (op < 1 || op > 12) return 0;
    if (usr && op >= 7) return 4;
    if (!rel) return 0;
    if (!hit) return 3;
    case (op)
      1: return (!wr || zdeny) ? 1 : 0;
      2, 3: return zdeny ? 2 : 0;
      4, 5, 6: return zdeny ? 1 : 0;
      7, 11: return !wr ? 2 : 0;
      default: return 0;
    endcase
  endfunction

  function automatic string tag_of(int op, bit usr, bit rel, bit hit);
    if (op < 1 || op > 12) return "R12";
    if (usr && op >= 7) return "R3";
    if (!rel) return "R4";
    if (!hit) return "R5";
    if (op == 1) return "R6";
    if (op <= 3) return "R7";
    if (op <= 6) return "R8";
    if (op == 7) return "R9";
    if (op <= 10) return "R10";
    return "R11";
  endfunction

  task automatic check(string tag, bit act_v, int act_c, bit exp_v, int exp_c);
    checks++;
    if (act_v !== exp_v || act_c !== exp_c) begin
      errors++;
      $display("FAIL %s valid=%0b code=%0d expected valid=%0b code=%0d",
               tag, act_v, act_c, exp_v, exp_c);
    end
  endtask

  bit    pend_v = 1'b0;
  int    pend_c = 0;
  string pend_t = "R1";

  // called at a negedge: check last cycle's request, then drive a new one
  task automatic step(bit v, int op, bit usr, bit rel, bit wr, int zn, bit hit);
    @(negedge clk_i);
    check(pend_t, rsp_valid_o, int'(rsp_code_o), pend_v, pend_v ? pend_c : 0);
    req_valid_i  = v;
    req_op_i     = op[3:0];
    user_mode_i  = usr;
    reloc_en_i   = rel;
    page_wr_en_i = wr;
    zone_code_i  = zn[1:0];
    xlat_hit_i   = hit;
    pend_v = v;
    pend_c = expect_code(op, usr, rel, wr, zn, hit);
    pend_t = v ? tag_of(op, usr, rel, hit) : "R1";
    if (v && zn != 0 && op >= 1 && op <= 6 && usr && rel && hit) pend_t = "R13";
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    check("R2", rsp_valid_o, int'(rsp_code_o), 1'b0, 0);
    rst_ni = 1'b1;
    // exhaustive back-to-back sweep
    for (int op = 0; op < 16; op++)
      for (int u = 0; u < 2; u++)
        for (int r = 0; r < 2; r++)
          for (int w = 0; w < 2; w++)
            for (int z = 0; z < 4; z++)
              for (int h = 0; h < 2; h++)
                step(1'b1, op, u[0], r[0], w[0], z, h[0]);
    // gaps: idle cycle must clear valid and code (R1)
    step(1'b1, 1, 1'b1, 1'b1, 1'b0, 0, 1'b1);
    step(1'b0, 7, 1'b1, 1'b1, 1'b0, 0, 1'b1);
    step(1'b1, 7, 1'b1, 1'b1, 1'b0, 0, 1'b1);
    step(1'b0, 0, 1'b0, 1'b0, 1'b0, 0, 1'b0);
    step(1'b0, 0, 1'b0, 1'b0, 1'b0, 0, 1'b0);
    // reset while a request is in flight (R2)
    step(1'b1, 2, 1'b1, 1'b1, 1'b1, 0, 1'b1);
    @(negedge clk_i);
    check("R7", rsp_valid_o, int'(rsp_code_o), 1'b1, 2);
    req_valid_i = 1'b0;
    rst_ni = 1'b0;
    #1;
    check("R2", rsp_valid_o, int'(rsp_code_o), 1'b0, 0);
    @(negedge clk_i);
    check("R2", rsp_valid_o, int'(rsp_code_o), 1'b0, 0);
    rst_ni = 1'b1;
    pend_v = 1'b0;
    pend_t = "R2";
    step(1'b1, 11, 1'b0, 1'b1, 1'b0, 1, 1'b1);
    step(1'b0, 0, 1'b0, 1'b0, 1'b0, 0, 1'b0);
    step(1'b0, 0, 1'b0, 1'b0, 1'b0, 0, 1'b0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R1 watchdog expired actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule